// File: doc/BRIEF.md
# DMA request source selector

This block sits in front of the request inputs of a DMA channel array. Each channel chooses which of its candidate peripheral request lines it listens to through a 4-bit selection field held in a register. The block then forwards that candidate's single-request strobe and burst-request strobe to the channel. Each candidate slot has a fixed class: single-only, burst-only, both, or reserved. A strobe kind that the slot's class does not support is held low. A reserved slot produces no strobe at all.

Software reaches the selection fields through a small word-addressed register bus. The fields are packed eight to a 32-bit word. A further word gives an older one-bit-per-channel view of the same fields. Reading that word reports whether each field is nonzero. Writing it forces each field to option 0 or option 1. The routing itself is combinational from the registered fields. The transfer engine and the arbitration between channels lie outside the block.

Top module: `dmasel_top`

## Requirements
- R1: When a channel's field holds an encoding below NUM_OPT (0 to 8 by default), the channel outputs follow the request lines of that candidate, at index channel*NUM_OPT+encoding of the source buses.
- R2: A field holding an encoding of NUM_OPT or above (9 to 15 by default) drives both channel outputs low, whatever the source lines do.
- R3: Reading the legacy word at address NUM_MAPREG (2 by default) returns, in bit n, 0 when channel n's field is 0 and 1 when it is any nonzero value. The upper bits read 0.
- R4: Writing the legacy word sets channel n's field to 0 when wdata bit n is 0, and to 1 when wdata bit n is 1.
- R5: A single-only candidate drives only ch_single and holds ch_burst low. A burst-only candidate drives only ch_burst and holds ch_single low. A candidate of class both passes both strobes. The class of each slot comes from dmasel_pkg::src_class(channel, option, CLASS_SEED).
- R6: A slot of reserved class produces no request on either output, even when its encoding is selected.
- R7: Channel n's field lives at bits [4*(n%8)+3 : 4*(n%8)] of the map word at address n/8. Writing a map word loads every field in it, and reading it back returns the fields at those positions. Addresses above the legacy word read 0 and ignore writes.
- R8: After reset, every field reads 0.
- R9: A written field steers the outputs from the cycle that follows the write edge. The fields keep their values while no write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | ADDR_W | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| src_single | input | NUM_CH*NUM_OPT | Single-request lines of all candidates |
| src_burst | input | NUM_CH*NUM_OPT | Burst-request lines of all candidates |
| ch_single | output | NUM_CH | Single request seen by each channel |
| ch_burst | output | NUM_CH | Burst request seen by each channel |

## Verification
Every channel is driven through every encoding: the valid ones, the reserved ones and slots of every class. The source lines are random on each cycle, so a stuck or swapped route shows up against the model. Using the same field value on all channels and then distinct values per channel exposes index and packing errors that a uniform pattern would hide. The legacy word is read over random fields, including values above 1, to tell a nonzero test apart from a bit-0 test. It is also written with random masks and read back through the map words, which separates an aliased write from a plain OR or from no effect.

// File: rtl/dmasel_pkg.sv
package dmasel_pkg;

   typedef enum logic [1:0] {
      CLS_NONE   = 2'd0,
      CLS_SINGLE = 2'd1,
      CLS_BURST  = 2'd2,
      CLS_BOTH   = 2'd3
   } cls_e;

   localparam int DATA_W = 32;

   // Fixed class of candidate slot (ch, opt); seed shifts the pattern
   function automatic cls_e src_class(input int ch, input int opt, input int seed);
      int h;
      h = (ch * 7 + opt * 3 + seed) % 5;
      case (h)
         0:       return CLS_NONE;
         1:       return CLS_SINGLE;
         2:       return CLS_BURST;
         default: return CLS_BOTH;
      endcase
   endfunction

endpackage

// File: rtl/dmasel_regs.sv
module dmasel_regs #(
   parameter int NUM_CH = 16,
   parameter int MAP_W  = 4,
   parameter int ADDR_W = 4
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic [ADDR_W-1:0]            reg_addr,
   input  logic                         reg_wr,
   input  logic [dmasel_pkg::DATA_W-1:0] reg_wdata,
   output logic [dmasel_pkg::DATA_W-1:0] reg_rdata,
   output logic [NUM_CH*MAP_W-1:0]      map_o
);
   localparam int FPR        = dmasel_pkg::DATA_W / MAP_W;
   localparam int NUM_MAPREG = (NUM_CH + FPR - 1) / FPR;
   localparam logic [ADDR_W-1:0] LEG_ADDR = ADDR_W'(NUM_MAPREG);

   logic [MAP_W-1:0] field_q [NUM_CH];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_field
      localparam int REG_IDX = c / FPR;
      localparam int SLOT    = c % FPR;
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_IDX);

      always_ff @(posedge clk) begin
         if (rst) begin
            field_q[c] <= '0;
         end else if (reg_wr && reg_addr == MY_ADDR) begin
            field_q[c] <= reg_wdata[SLOT*MAP_W +: MAP_W];
         end else if (reg_wr && reg_addr == LEG_ADDR) begin
            field_q[c] <= {{(MAP_W-1){1'b0}}, reg_wdata[c]};
         end
      end

      assign map_o[c*MAP_W +: MAP_W] = field_q[c];

      assert_map_write_R7: assert property (@(posedge clk) disable iff (rst)
         (reg_wr && reg_addr == MY_ADDR) |=>
            map_o[c*MAP_W +: MAP_W] == $past(reg_wdata[SLOT*MAP_W +: MAP_W]));

      assert_legacy_write_R4: assert property (@(posedge clk) disable iff (rst)
         (reg_wr && reg_addr == LEG_ADDR) |=>
            map_o[c*MAP_W +: MAP_W] == {{(MAP_W-1){1'b0}}, $past(reg_wdata[c])});

      assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
         !reg_wr |=> $stable(map_o[c*MAP_W +: MAP_W]));

      assert_legacy_read_R3: assert property (@(posedge clk) disable iff (rst)
         (reg_addr == LEG_ADDR && map_o[c*MAP_W +: MAP_W] == '0) |-> !reg_rdata[c]);
   end

   always_comb begin
      reg_rdata = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (reg_addr == LEG_ADDR) begin
            reg_rdata[c] = |field_q[c];
         end else if (reg_addr == ADDR_W'(c / FPR)) begin
            reg_rdata[(c % FPR)*MAP_W +: MAP_W] = field_q[c];
         end
      end
   end

endmodule

// File: rtl/dmasel_chan_mux.sv
module dmasel_chan_mux #(
   parameter int CH         = 0,
   parameter int NUM_OPT    = 9,
   parameter int MAP_W      = 4,
   parameter int CLASS_SEED = 0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [MAP_W-1:0]   sel,
   input  logic [NUM_OPT-1:0] src_single,
   input  logic [NUM_OPT-1:0] src_burst,
   output logic               req_single,
   output logic               req_burst
);
   logic [NUM_OPT-1:0] s_ok;
   logic [NUM_OPT-1:0] b_ok;

   for (genvar o = 0; o < NUM_OPT; o++) begin : g_opt
      localparam dmasel_pkg::cls_e CLS = dmasel_pkg::src_class(CH, o, CLASS_SEED);
      localparam logic [MAP_W-1:0] ENC = MAP_W'(o);

      if (CLS == dmasel_pkg::CLS_BOTH) begin : g_both
         assign s_ok[o] = src_single[o];
         assign b_ok[o] = src_burst[o];
      end else if (CLS == dmasel_pkg::CLS_SINGLE) begin : g_single
         logic unused_b;
         assign unused_b = src_burst[o];
         assign s_ok[o] = src_single[o];
         assign b_ok[o] = 1'b0;
         assert_single_only_R5: assert property (@(posedge clk) disable iff (rst)
            (sel == ENC) |-> (!req_burst && req_single == src_single[o]));
      end else if (CLS == dmasel_pkg::CLS_BURST) begin : g_burst
         logic unused_s;
         assign unused_s = src_single[o];
         assign s_ok[o] = 1'b0;
         assign b_ok[o] = src_burst[o];
         assert_burst_only_R5: assert property (@(posedge clk) disable iff (rst)
            (sel == ENC) |-> (!req_single && req_burst == src_burst[o]));
      end else begin : g_none
         logic unused_sb;
         assign unused_sb = src_single[o] ^ src_burst[o];
         assign s_ok[o] = 1'b0;
         assign b_ok[o] = 1'b0;
         assert_reserved_slot_R6: assert property (@(posedge clk) disable iff (rst)
            (sel == ENC) |-> (!req_single && !req_burst));
      end
   end

   always_comb begin
      req_single = 1'b0;
      req_burst  = 1'b0;
      for (int o = 0; o < NUM_OPT; o++) begin
         if (int'(sel) == o) begin
            req_single = s_ok[o];
            req_burst  = b_ok[o];
         end
      end
   end

   assert_reserved_enc_R2: assert property (@(posedge clk) disable iff (rst)
      (int'(sel) >= NUM_OPT) |-> (!req_single && !req_burst));

endmodule

// File: rtl/dmasel_top.sv
module dmasel_top #(
   parameter int NUM_CH     = 16,
   parameter int NUM_OPT    = 9,
   parameter int MAP_W      = 4,
   parameter int ADDR_W     = 4,
   parameter int CLASS_SEED = 0
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic [ADDR_W-1:0]           reg_addr,
   input  logic                        reg_wr,
   input  logic [31:0]                 reg_wdata,
   output logic [31:0]                 reg_rdata,
   input  logic [NUM_CH*NUM_OPT-1:0]   src_single,
   input  logic [NUM_CH*NUM_OPT-1:0]   src_burst,
   output logic [NUM_CH-1:0]           ch_single,
   output logic [NUM_CH-1:0]           ch_burst
);
   localparam int FPR        = dmasel_pkg::DATA_W / MAP_W;
   localparam int NUM_MAPREG = (NUM_CH + FPR - 1) / FPR;

   if (NUM_CH < 1 || NUM_CH > dmasel_pkg::DATA_W) begin : g_bad_ch
      $error("NUM_CH must be 1 to 32");
   end
   if (NUM_OPT < 2 || NUM_OPT > (1 << MAP_W)) begin : g_bad_opt
      $error("NUM_OPT must be at least 2 and fit the field");
   end
   if (dmasel_pkg::DATA_W % MAP_W != 0) begin : g_bad_w
      $error("MAP_W must divide the word width");
   end
   if (NUM_MAPREG + 1 > (1 << ADDR_W)) begin : g_bad_a
      $error("ADDR_W too small for map and legacy words");
   end

   logic [NUM_CH*MAP_W-1:0] map;

   dmasel_regs #(.NUM_CH(NUM_CH), .MAP_W(MAP_W), .ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst       (rst),
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .map_o     (map)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      dmasel_chan_mux #(
         .CH(c), .NUM_OPT(NUM_OPT), .MAP_W(MAP_W), .CLASS_SEED(CLASS_SEED)
      ) u_mux (
         .clk        (clk),
         .rst        (rst),
         .sel        (map[c*MAP_W +: MAP_W]),
         .src_single (src_single[c*NUM_OPT +: NUM_OPT]),
         .src_burst  (src_burst[c*NUM_OPT +: NUM_OPT]),
         .req_single (ch_single[c]),
         .req_burst  (ch_burst[c])
      );
   end

endmodule

// File: tb/tb_dmasel_top.sv
`timescale 1ns/1ps
module tb_dmasel_top;
   localparam int NCH  = 16;
   localparam int NOPT = 9;
   localparam int AW   = 4;
   localparam int SEED = 0;
   localparam int NMAP = 2;
   localparam int LEG  = 2;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [AW-1:0] reg_addr = '0;
   logic reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [NCH*NOPT-1:0] src_single = '0;
   logic [NCH*NOPT-1:0] src_burst = '0;
   logic [NCH-1:0] ch_single, ch_burst;

   int checks = 0;
   int errors = 0;
   int model_map [NCH];
   bit done = 0;

   always #2.5 clk = ~clk;

   dmasel_top dut (
      .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .src_single(src_single), .src_burst(src_burst),
      .ch_single(ch_single), .ch_burst(ch_burst)
   );

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   function automatic logic [31:0] exp_rdata(input int addr);
      logic [31:0] r = '0;
      for (int c = 0; c < NCH; c++) begin
         if (addr == LEG) r[c] = (model_map[c] != 0);
         else if (addr == c / 8) r[(c % 8)*4 +: 4] = 4'(model_map[c]);
      end
      return r;
   endfunction

   task automatic compare(input string req);
      logic [NCH-1:0] es = '0, eb = '0;
      logic [31:0] er;
      for (int c = 0; c < NCH; c++) begin
         int e = model_map[c];
         if (e < NOPT) begin
            dmasel_pkg::cls_e k = dmasel_pkg::src_class(c, e, SEED);
            es[c] = src_single[c*NOPT+e] &&
                    (k == dmasel_pkg::CLS_SINGLE || k == dmasel_pkg::CLS_BOTH);
            eb[c] = src_burst[c*NOPT+e] &&
                    (k == dmasel_pkg::CLS_BURST || k == dmasel_pkg::CLS_BOTH);
         end
      end
      checks++;
      if (ch_single !== es || ch_burst !== eb) begin
         errors++;
         $display("FAIL %s routing: single %h burst %h expected %h %h",
                  req, ch_single, ch_burst, es, eb);
      end
      er = exp_rdata(int'(reg_addr));
      checks++;
      if (reg_rdata !== er) begin
         errors++;
         $display("FAIL %s read addr %0d: got %h expected %h", req, reg_addr, reg_rdata, er);
      end
   endtask

   // drive at negedge, model updates at the write edge, check next negedge
   task automatic step(input bit wr, input int addr, input logic [31:0] wd, input string req);
      reg_wr    = wr;
      reg_addr  = AW'(addr);
      reg_wdata = wd;
      for (int i = 0; i < NCH*NOPT; i++) begin
         src_single[i] = 1'($urandom);
         src_burst[i]  = 1'($urandom);
      end
      @(posedge clk);
      if (wr) begin
         for (int c = 0; c < NCH; c++) begin
            if (addr == c / 8) model_map[c] = int'(wd[(c % 8)*4 +: 4]);
            else if (addr == LEG) model_map[c] = int'(wd[c]);
         end
      end
      @(negedge clk);
      compare(req);
   endtask

   initial begin
      for (int c = 0; c < NCH; c++) model_map[c] = 0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R8: reset state of every map word and the legacy word
      for (int a = 0; a <= LEG; a++) step(0, a, '0, "R8");

      // R1 R6 R5: every encoding below NUM_OPT on all channels, same value
      for (int e = 0; e < NOPT; e++) begin
         logic [31:0] w = {8{4'(e)}};
         step(1, 0, w, "R1");
         step(1, 1, w, "R9");
         for (int k = 0; k < 6; k++) step(0, k % 3, '0, "R5");
         for (int k = 0; k < 4; k++) step(0, 0, '0, "R6");
      end

      // R2: reserved encodings on all channels
      for (int e = NOPT; e < 16; e++) begin
         logic [31:0] w = {8{4'(e)}};
         step(1, 0, w, "R2");
         step(1, 1, w, "R2");
         for (int k = 0; k < 6; k++) step(0, k % 2, '0, "R2");
      end

      // R7: distinct per-channel fields, packing and readback
      for (int k = 0; k < 20; k++) begin
         step(1, k % 2, $urandom, "R7");
         step(0, 0, '0, "R7");
         step(0, 1, '0, "R7");
      end
      // R7: out-of-range address ignored and reads zero
      step(1, 5, 32'hFFFF_FFFF, "R7");
      step(0, 0, '0, "R7");
      step(0, 1, '0, "R7");
      step(0, 5, '0, "R7");

      // R3: legacy read over random fields including values above 1
      for (int k = 0; k < 20; k++) begin
         step(1, k % 2, $urandom, "R3");
         step(0, LEG, '0, "R3");
      end

      // R4: legacy write aliases onto fields as 0 or 1
      for (int k = 0; k < 20; k++) begin
         step(1, 0, 32'h9999_9999, "R4");
         step(1, 1, 32'h7777_7777, "R4");
         step(1, LEG, $urandom, "R4");
         step(0, 0, '0, "R4");
         step(0, 1, '0, "R4");
         step(0, LEG, '0, "R4");
      end

      // R8: reset again clears fields
      step(1, 0, 32'h3333_3333, "R8");
      rst = 1'b1;
      @(posedge clk);
      for (int c = 0; c < NCH; c++) model_map[c] = 0;
      @(negedge clk);
      rst = 1'b0;
      step(0, 0, '0, "R8");
      step(0, 1, '0, "R8");
      step(0, 0, '0, "R8");
      finish_run();
   end
endmodule